// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block runs the hardware part of a processor's exception entry. Each cycle it holds a set of pending exception bits and a set of active exception bits, both indexed by exception number. A lower number means higher priority. The block starts an entry when the highest-priority pending exception outranks every active one. It then saves the interrupted context to memory below the current stack pointer as a fixed frame, writing one word per cycle. In the same cycle it issues the read of the handler address from the vector table, so the read runs alongside the writes.

A frame is either 8 words (integer context) or 26 words (integer context plus floating-point context). The block picks the word to store through an indexed context port. It can lower the stack pointer by one word first, so the frame starts on an 8-byte boundary, and it records that adjustment inside the saved status word. The handler starts once every frame write is issued and the matching vector word has returned. At that point the block reports the handler address, the new stack pointer, the exception number and a link return code, and it moves the exception from pending to active.

A higher-priority exception can arrive while an entry is in progress. In that case the block keeps the frame it is already writing and fetches only the new vector. The displaced exception stays pending.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `done`, `mw_en` and `vr_en` are low, and `pend_o` and `act_o` are all zero.
- R2: A `pend_set` pulse sets its pending bit one cycle later. An entry starts for the lowest-numbered pending exception, but only when that number is lower than every active exception number (or nothing is active). Otherwise no write and no vector read takes place.
- R3: The frame has N words, with N = 8 when `fp_ctx` is 0 and N = 26 when it is 1. Word i goes to address B + 4*i, where B = S - 4*N and S is the adjusted stack pointer. The words are written on consecutive cycles in ascending i. For each word, `ctx_sel` equals i and the data is `ctx_word`. Index 6 carries the supplied return address, the next instruction of the interrupted code.
- R4: If `stkalign` is 1 and `sp_in` bit 2 is 1, then S = `sp_in` - 4. Otherwise S = `sp_in`. The status word at index 7 is written with bit 9 equal to that adjustment flag and all other bits taken from `ctx_word`. In a 26-word frame, index 25 is a filler and is written as zero.
- R5: The vector read is issued as a one-cycle `vr_en` pulse at address `vtor` + 4*number. It goes out in the cycle after the entry starts, before the first frame write appears.
- R6: `done` is a one-cycle pulse. It comes only after all N writes and after the vector word for the final exception number has arrived. At `done`, `hdl_addr` holds that vector word and `sp_out` holds B.
- R7: At `done`, `exc_ret` = {27 ones, ~fp, code}. Here code is 4'h1 when `thread_mode` is 0, 4'h9 in thread mode with `use_psp` 0, and 4'hD in thread mode with `use_psp` 1.
- R8: At `done`, the pending bit of `exc_num_o` is clear and its active bit is set.
- R9: A pending exception with a lower number than the current target, arriving before `done`, becomes the new target. No extra frame is written, and a new vector read is issued for it. The earlier exception stays pending and does not become active. A higher-numbered arrival leaves the entry unchanged.
- R10: A vector word that returns for a target that has since been replaced is discarded and never reaches `hdl_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_set | input | NUM_EXC | One-cycle request pulses, one per exception number |
| vtor | input | 32 | Vector table base address |
| sp_in | input | 32 | Stack pointer before entry (word aligned) |
| fp_ctx | input | 1 | Save the extended floating-point frame |
| stkalign | input | 1 | Enable 8-byte frame alignment |
| use_psp | input | 1 | Frame goes on the process stack |
| thread_mode | input | 1 | Interrupted code ran in thread mode |
| ctx_sel | output | 5 | Frame word index being fetched from the context |
| ctx_word | input | 32 | Context word selected by `ctx_sel` |
| mw_en | output | 1 | Memory write strobe |
| mw_addr | output | 32 | Memory write address |
| mw_data | output | 32 | Memory write data |
| vr_en | output | 1 | Vector read request pulse |
| vr_addr | output | 32 | Vector read address |
| vr_valid | input | 1 | Vector read data valid |
| vr_data | input | 32 | Vector read data |
| done | output | 1 | Handler start pulse |
| exc_num_o | output | EXC_W | Exception number being entered |
| hdl_addr | output | 32 | Handler start address |
| sp_out | output | 32 | Stack pointer after stacking |
| exc_ret | output | 32 | Link return code |
| pend_o | output | NUM_EXC | Pending status bits |
| act_o | output | NUM_EXC | Active status bits |

## Verification
The assertions assume three things about the environment: `sp_in` and `vtor` are word aligned, the vector port sends exactly one `vr_valid` per request and at least one cycle after it, and `ctx_word` follows `ctx_sel` within the same cycle. The bench's vector responder answers each pulse exactly once, after a programmable latency of one or more cycles. It drives only word-aligned stack and table addresses, and it computes the context word combinationally from the index. The sweep covers every combination of frame type, alignment enable, misaligned stack, stack choice and mode. It adds late arrivals that land before and after the first vector word returns, a lower-priority arrival, and an entry blocked by an active exception.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int WORD_W      = 32;
  localparam int BASIC_WORDS = 8;
  localparam int EXT_WORDS   = 26;
  localparam int XPSR_IDX    = 7;
  localparam int PAD_BIT     = 9;
  localparam int IDX_W       = $clog2(EXT_WORDS);

  typedef enum logic [1:0] {ST_IDLE, ST_STACK, ST_WAIT} seq_state_t;

  function automatic logic [WORD_W-1:0] ret_code(logic ext, logic thread, logic psp);
    logic [3:0] lo;
    lo = !thread ? 4'h1 : (psp ? 4'hD : 4'h9);
    return {27'h7FF_FFFF, ~ext, lo};
  endfunction
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 16,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  // lowest set index wins: scan downward, last hit is kept
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/exc_frame_gen.sv
module exc_frame_gen
  import exc_entry_pkg::*;
(
  input  logic [WORD_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] ctx,
  input  logic              pad,
  input  logic              ext,
  output logic [WORD_W-1:0] addr,
  output logic [WORD_W-1:0] data
);
  assign addr = base + {{(WORD_W-IDX_W-2){1'b0}}, idx, 2'b00};

  always_comb begin
    data = ctx;
    if (ext && int'(idx) == EXT_WORDS - 1) begin
      data = '0;
    end else if (int'(idx) == XPSR_IDX) begin
      data[PAD_BIT] = pad;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int NUM_EXC = 16,
  parameter int EXC_W   = $clog2(NUM_EXC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXC-1:0] pend_set,
  input  logic [31:0]        vtor,
  input  logic [31:0]        sp_in,
  input  logic               fp_ctx,
  input  logic               stkalign,
  input  logic               use_psp,
  input  logic               thread_mode,
  output logic [4:0]         ctx_sel,
  input  logic [31:0]        ctx_word,
  output logic               mw_en,
  output logic [31:0]        mw_addr,
  output logic [31:0]        mw_data,
  output logic               vr_en,
  output logic [31:0]        vr_addr,
  input  logic               vr_valid,
  input  logic [31:0]        vr_data,
  output logic               done,
  output logic [EXC_W-1:0]   exc_num_o,
  output logic [31:0]        hdl_addr,
  output logic [31:0]        sp_out,
  output logic [31:0]        exc_ret,
  output logic [NUM_EXC-1:0] pend_o,
  output logic [NUM_EXC-1:0] act_o
);
  localparam logic [31:0] BASIC_BYTES = 32'(BASIC_WORDS * 4);
  localparam logic [31:0] EXT_BYTES   = 32'(EXT_WORDS * 4);

  seq_state_t         state;
  logic [EXC_W-1:0]   tgt;
  logic [IDX_W-1:0]   wcnt;
  logic               ext_q, pad_q, thread_q, psp_q;
  logic [31:0]        base_q;
  logic               vwait, vhave;
  logic [EXC_W-1:0]   vnum;
  logic [31:0]        vdata;
  logic [NUM_EXC-1:0] pend_q, act_q;

  logic             p_any, a_any;
  logic [EXC_W-1:0] p_idx, a_idx;

  exc_prio_pick #(.N(NUM_EXC), .W(EXC_W)) u_pick_pend (
    .req(pend_q), .found(p_any), .idx(p_idx));
  exc_prio_pick #(.N(NUM_EXC), .W(EXC_W)) u_pick_act (
    .req(act_q), .found(a_any), .idx(a_idx));

  logic             busy, start, late, go;
  logic [EXC_W-1:0] nt;
  logic             pad_now;
  logic [31:0]      adj_sp;
  logic [IDX_W-1:0] last_idx;

  assign busy     = (state != ST_IDLE);
  assign start    = !busy && p_any && (!a_any || p_idx < a_idx);
  assign late     = busy && p_any && (p_idx < tgt);
  assign nt       = late ? p_idx : tgt;
  assign go       = (state == ST_WAIT) && vhave && (vnum == tgt) && !late;
  assign pad_now  = stkalign & sp_in[2];
  assign adj_sp   = sp_in - {29'd0, pad_now, 2'b00};
  assign last_idx = ext_q ? IDX_W'(EXT_WORDS - 1) : IDX_W'(BASIC_WORDS - 1);

  logic [31:0] fg_addr, fg_data;
  exc_frame_gen u_frame (
    .base(base_q), .idx(wcnt), .ctx(ctx_word), .pad(pad_q), .ext(ext_q),
    .addr(fg_addr), .data(fg_data));

  assign ctx_sel = wcnt;

  // entry sequence and frame writes
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tgt       <= '0;
      wcnt      <= '0;
      ext_q     <= 1'b0;
      pad_q     <= 1'b0;
      thread_q  <= 1'b0;
      psp_q     <= 1'b0;
      base_q    <= '0;
      mw_en     <= 1'b0;
      mw_addr   <= '0;
      mw_data   <= '0;
      done      <= 1'b0;
      exc_num_o <= '0;
      hdl_addr  <= '0;
      sp_out    <= '0;
      exc_ret   <= '0;
    end else begin
      mw_en <= 1'b0;
      done  <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          tgt      <= p_idx;
          ext_q    <= fp_ctx;
          pad_q    <= pad_now;
          thread_q <= thread_mode;
          psp_q    <= use_psp;
          base_q   <= adj_sp - (fp_ctx ? EXT_BYTES : BASIC_BYTES);
          wcnt     <= '0;
          state    <= ST_STACK;
        end
        ST_STACK: begin
          mw_en   <= 1'b1;
          mw_addr <= fg_addr;
          mw_data <= fg_data;
          wcnt    <= wcnt + 1'b1;
          if (wcnt == last_idx) state <= ST_WAIT;
        end
        default: if (go) begin
          done      <= 1'b1;
          hdl_addr  <= vdata;
          sp_out    <= base_q;
          exc_ret   <= ret_code(ext_q, thread_q, psp_q);
          exc_num_o <= tgt;
          wcnt      <= '0;
          state     <= ST_IDLE;
        end
      endcase
      if (late) tgt <= p_idx;
    end
  end

  // vector fetch tracker, runs beside the frame writes
  always_ff @(posedge clk) begin
    if (rst) begin
      vr_en   <= 1'b0;
      vr_addr <= '0;
      vwait   <= 1'b0;
      vhave   <= 1'b0;
      vnum    <= '0;
      vdata   <= '0;
    end else begin
      vr_en <= 1'b0;
      if (start) begin
        vr_en   <= 1'b1;
        vr_addr <= vtor + (32'(p_idx) << 2);
        vnum    <= p_idx;
        vwait   <= 1'b1;
        vhave   <= 1'b0;
      end else if (vwait) begin
        if (vr_valid) begin
          vwait <= 1'b0;
          vhave <= (vnum == nt);
          vdata <= vr_data;
        end
      end else if (busy && !go && !(vhave && vnum == nt)) begin
        vr_en   <= 1'b1;
        vr_addr <= vtor + (32'(nt) << 2);
        vnum    <= nt;
        vwait   <= 1'b1;
        vhave   <= 1'b0;
      end
    end
  end

  // per-exception status bits
  for (genvar g = 0; g < NUM_EXC; g++) begin : g_stat
    logic clr_g;
    assign clr_g = go && (tgt == EXC_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[g] <= 1'b0;
        act_q[g]  <= 1'b0;
      end else begin
        pend_q[g] <= (pend_q[g] | pend_set[g]) & ~clr_g;
        act_q[g]  <= act_q[g] | clr_g;
      end
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int NUM_EXC = 16,
  parameter int EXC_W   = $clog2(NUM_EXC)
) (
  input logic               clk,
  input logic               rst,
  input logic               done,
  input logic               mw_en,
  input logic [31:0]        mw_addr,
  input logic               vr_en,
  input logic [31:0]        exc_ret,
  input logic [EXC_W-1:0]   exc_num_o,
  input logic [NUM_EXC-1:0] act_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!done && !mw_en && !vr_en && act_o == '0));

  assert_word_addr_R3: assert property (@(posedge clk) disable iff (rst)
    mw_en |-> (mw_addr[1:0] == 2'b00));

  assert_vec_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    vr_en |=> !vr_en);

  assert_no_write_at_start_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !mw_en);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_ret_form_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (exc_ret[31:5] == 27'h7FF_FFFF &&
              (exc_ret[3:0] == 4'h1 || exc_ret[3:0] == 4'h9 || exc_ret[3:0] == 4'hD)));

  assert_active_set_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> act_o[exc_num_o]);
endmodule

bind exc_entry_seq exc_entry_chk #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W)) u_chk (
  .clk(clk), .rst(rst), .done(done), .mw_en(mw_en), .mw_addr(mw_addr),
  .vr_en(vr_en), .exc_ret(exc_ret), .exc_num_o(exc_num_o), .act_o(act_o));

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  localparam int NUM_EXC = 16;
  localparam int EXC_W   = 4;
  localparam logic [31:0] VTOR = 32'h2000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_EXC-1:0] pend_set = '0;
  logic [31:0] sp_in = '0;
  logic fp_ctx = 0, stkalign = 0, use_psp = 0, thread_mode = 0;
  logic [4:0]  ctx_sel;
  logic [31:0] ctx_word;
  logic mw_en, vr_en, vr_valid, done;
  logic [31:0] mw_addr, mw_data, vr_addr, vr_data, hdl_addr, sp_out, exc_ret;
  logic [EXC_W-1:0] exc_num_o;
  logic [NUM_EXC-1:0] pend_o, act_o;
  logic [31:0] salt = '0;

  always #2 clk = ~clk;

  assign ctx_word = salt ^ (32'(ctx_sel) * 32'h0101_0101);

  exc_entry_seq #(.NUM_EXC(NUM_EXC)) dut (
    .clk(clk), .rst(rst), .pend_set(pend_set), .vtor(VTOR), .sp_in(sp_in),
    .fp_ctx(fp_ctx), .stkalign(stkalign), .use_psp(use_psp), .thread_mode(thread_mode),
    .ctx_sel(ctx_sel), .ctx_word(ctx_word), .mw_en(mw_en), .mw_addr(mw_addr),
    .mw_data(mw_data), .vr_en(vr_en), .vr_addr(vr_addr), .vr_valid(vr_valid),
    .vr_data(vr_data), .done(done), .exc_num_o(exc_num_o), .hdl_addr(hdl_addr),
    .sp_out(sp_out), .exc_ret(exc_ret), .pend_o(pend_o), .act_o(act_o));

  int n_chk = 0, n_bad = 0;
  int lat = 1;
  int wr_cnt = 0, vr_cnt = 0, first_wr = -1;
  logic [31:0] vr_last = '0;
  logic [31:0] exp_base = '0;
  logic exp_pad = 0, exp_ext = 0;

  function automatic logic [31:0] vec_fn(logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // vector table responder
  int vcnt = 0;
  logic [31:0] vaddr_q = '0;
  always @(posedge clk) begin
    if (rst) begin
      vcnt <= 0; vr_valid <= 1'b0; vr_data <= '0;
    end else begin
      vr_valid <= 1'b0;
      if (vr_en) begin
        vcnt <= lat; vaddr_q <= vr_addr;
      end else if (vcnt == 1) begin
        vr_valid <= 1'b1; vr_data <= vec_fn(vaddr_q); vcnt <= 0;
      end else if (vcnt > 1) vcnt <= vcnt - 1;
    end
  end

  // write / request monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (mw_en) begin
        logic [31:0] w;
        w = salt ^ (32'(wr_cnt) * 32'h0101_0101);
        if (exp_ext && wr_cnt == 25) w = '0;
        else if (wr_cnt == 7) w[9] = exp_pad;
        chk("R3 frame word address", mw_addr, exp_base + 32'(4 * wr_cnt));
        chk("R3/R4 frame word data", mw_data, w);
        wr_cnt++;
      end
      if (vr_en) begin
        if (vr_cnt == 0) first_wr = wr_cnt;
        vr_cnt++;
        vr_last = vr_addr;
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1; pend_set = '0;
    repeat (3) @(negedge clk);
    chk("R1 mw_en in reset", 32'(mw_en), 0);
    chk("R1 done in reset", 32'(done), 0);
    chk("R1 vr_en in reset", 32'(vr_en), 0);
    chk("R1 pend_o in reset", 32'(pend_o), 0);
    chk("R1 act_o in reset", 32'(act_o), 0);
    #1 rst = 1'b0;
  endtask

  task automatic run_entry(int num, bit fp, bit al, bit spb, bit psp, bit thr,
                           int latency, int late_num, int late_at, bit do_rst,
                           int exp_num, int exp_vr, int idx);
    int t, since;
    logic [31:0] sp, code;
    if (do_rst) do_reset();
    sp = 32'h2000_8000 - 32'(idx * 64) + (spb ? 32'd4 : 32'd0);
    sp_in = sp; fp_ctx = fp; stkalign = al; use_psp = psp; thread_mode = thr;
    lat = latency;
    salt = {idx[7:0], 24'h5A_0000} ^ (32'(idx) << 9);
    exp_pad = al & spb; exp_ext = fp;
    exp_base = (sp - (exp_pad ? 32'd4 : 32'd0)) - (fp ? 32'd104 : 32'd32);
    wr_cnt = 0; vr_cnt = 0; first_wr = -1; since = 0;
    pend_set = 16'(1 << num);
    @(negedge clk); #1 pend_set = '0;
    for (t = 0; t < 300; t++) begin
      @(negedge clk); #1;
      if (done) break;
      pend_set = '0;
      if (late_num >= 0 && vr_cnt > 0) begin
        since++;
        if (since == late_at) pend_set = 16'(1 << late_num);
      end
    end
    pend_set = '0;
    if (t >= 300) begin
      n_chk++; n_bad++;
      $display("FAIL R6 no handler start actual=0 expected=1");
    end else begin
      code = {27'h7FF_FFFF, ~fp, (!thr ? 4'h1 : (psp ? 4'hD : 4'h9))};
      chk("R2/R9 entered number", 32'(exc_num_o), 32'(exp_num));
      chk("R6 handler address", hdl_addr, vec_fn(VTOR + 32'(4 * exp_num)));
      chk("R3/R4 new stack pointer", sp_out, exp_base);
      chk("R7 return code", exc_ret, code);
      chk("R6/R9 frame word count", 32'(wr_cnt), fp ? 32'd26 : 32'd8);
      chk("R9/R10 vector request count", 32'(vr_cnt), 32'(exp_vr));
      chk("R5 vector address", vr_last, VTOR + 32'(4 * exp_num));
      chk("R5 vector read before first write", 32'(first_wr), 0);
      chk("R8 active set", 32'(act_o[exp_num]), 1);
      chk("R8 pending cleared", 32'(pend_o[exp_num]), 0);
      if (exp_num != num) begin
        chk("R9 displaced stays pending", 32'(pend_o[num]), 1);
        chk("R9 displaced not active", 32'(act_o[num]), 0);
      end
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // sweep: frame type, alignment enable, misaligned SP, stack choice, mode
    for (int i = 0; i < 32; i++) begin
      run_entry((i * 7) % NUM_EXC, i[0], i[1], i[2], i[3], i[4],
                1 + (i % 4), -1, 0, 1'b1, (i * 7) % NUM_EXC, 1, i);
    end
    // R9: late arrival of higher priority, early (first vector still in flight)
    run_entry(9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1, 4, 1, 1'b1, 4, 2, 40);
    // R10: stale vector response with long latency, extended frame
    run_entry(9, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 12, 2, 2, 1'b1, 2, 2, 41);
    // R9: late arrival after first vector returned
    run_entry(11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2, 5, 6, 1'b1, 5, 2, 42);
    // R9: lower-priority arrival leaves entry unchanged
    run_entry(9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2, 12, 1, 1'b1, 9, 1, 43);
    chk("R9 lower priority stays pending", 32'(pend_o[12]), 1);
    // R2: blocked by active exception, then preempted by higher priority
    run_entry(3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1, -1, 0, 1'b1, 3, 1, 44);
    vr_cnt = 0; wr_cnt = 0;
    pend_set = 16'(1 << 7);
    @(negedge clk); #1 pend_set = '0;
    repeat (20) @(negedge clk);
    #1;
    chk("R2 blocked no vector read", 32'(vr_cnt), 0);
    chk("R2 blocked no write", 32'(wr_cnt), 0);
    chk("R2 blocked stays pending", 32'(pend_o[7]), 1);
    chk("R2 blocked not active", 32'(act_o[7]), 0);
    run_entry(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3, -1, 0, 1'b0, 1, 1, 45);
    chk("R8 nested active set", 32'(act_o), 32'h0000_000A);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule